// File: doc/BRIEF.md
# Gate Shutdown Control Target on a Two-Wire Bus

This block is a two-wire serial bus target that runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an open-drain enable. A controller selects the block with an address byte. The upper nibble of that byte is a fixed device type, the next three bits are compared with three strap pins, and the lowest bit gives the direction. The controller then sends a register pointer byte, and after that either one data byte to write, or a repeated start followed by a read address and one byte returned by the block.

Two registers sit behind the pointer. The status register reports three gate status inputs and a volatile write-enable latch. The shutdown register holds a two-bit override code that is driven straight out to the gate control logic. Writes to the shutdown register are accepted only while the latch is set. Otherwise the data byte is refused with a NACK and dropped.

Top module: `gatectl_i2c_top`

## Requirements
- R1: An address byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `addr_pins_i[2:0]`. Bit 0 selects read (1) or write (0). After a mismatch the block acknowledges nothing and drives nothing until the next start or stop.
- R2: In a write transfer, the pointer byte and the data byte are acknowledged (low on SDA during the ninth clock), except in the case of R5.
- R3: A read of pointer 00h returns bits 7..4 = 0, bit 3 = `gate_stat_i[2]` (high gate), bit 2 = `gate_stat_i[1]` (mid gate), bit 1 = `gate_stat_i[0]` (low gate), and bit 0 = the write-enable latch.
- R4: The latch is 0 after reset. Writing 01h to pointer 00h sets it, writing 00h clears it, and writing any other value to 00h leaves it unchanged.
- R5: While the latch is 0, a data byte written to pointer FFh gets no acknowledge, and `shdn_o` keeps its value.
- R6: While the latch is 1, a data byte written to pointer FFh is acknowledged, its bits 1..0 appear on `shdn_o`, and a read of FFh returns {6'b0, shdn_o}.
- R7: A random read, made of a write of the pointer, a repeated start and a read address byte, returns one byte from that pointer MSB first. SDA changes only while SCL is low.
- R8: A stop or start condition in the middle of a byte aborts the transfer and commits no write. The next transfer works normally, and after a stop SDA is released.
- R9: After reset `sda_oe_o` is 0 and `shdn_o` is 0.
- R10: Pointers other than 00h and FFh acknowledge a data byte, have no effect, and read back as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (as seen on the wire) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_pins_i | input | 3 | Address strap pins compared with address bits 3..1 |
| gate_stat_i | input | 3 | Gate status: [2] high, [1] mid, [0] low |
| shdn_o | output | 2 | Stored shutdown override code |

## Verification
The hardest situation to bring about is a transfer that breaks off partway through a byte. In that case the shift register already holds some bits of a shutdown code, and a write must not commit. The stimulus sets the latch, sends a pointer to the shutdown register, clocks in only a few data bits and then issues a stop, or a start that begins a new transfer. It then checks at the ports that `shdn_o` and the read-back value did not change. The refused write, meaning a NACK on the data byte, comes up in the random mix whenever the latch model is clear. This makes the bench check the acknowledge bit itself, not only the register contents.

// File: rtl/gatectl_i2c_pkg.sv
package gatectl_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [BYTE_W-1:0] PTR_STATUS = 8'h00;
  localparam logic [BYTE_W-1:0] PTR_SHDN   = 8'hFF;
  localparam logic [BYTE_W-1:0] WEL_SET    = 8'h01;
  localparam logic [BYTE_W-1:0] WEL_CLR    = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/gatectl_i2c_line_sync.sv
module gatectl_i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // one extra stage beyond the synchroniser gives the previous sample
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_now  = sda_pipe[SYNC_STAGES-1];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign scl_o      = scl_now;
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/gatectl_i2c_regs.sv
module gatectl_i2c_regs
  import gatectl_i2c_pkg::*;
#(
  parameter int GATE_N = 3,
  parameter int SHDN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [GATE_N-1:0] gate_stat_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              wel_o,
  output logic [SHDN_W-1:0] shdn_o
);
  logic              wel_q;
  logic [SHDN_W-1:0] shdn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      shdn_q <= '0;
    end else if (wr_en_i) begin
      if (ptr_i == PTR_STATUS) begin
        if (wr_data_i == WEL_SET)      wel_q <= 1'b1;
        else if (wr_data_i == WEL_CLR) wel_q <= 1'b0;
      end
      if (ptr_i == PTR_SHDN && wel_q) shdn_q <= wr_data_i[SHDN_W-1:0];
    end
  end

  logic [BYTE_W-1:0] status_w, shdn_w;
  always_comb begin
    status_w = '0;
    status_w[GATE_N:1] = gate_stat_i;
    status_w[0] = wel_q;
    shdn_w = '0;
    shdn_w[SHDN_W-1:0] = shdn_q;
    if (ptr_i == PTR_STATUS)    rd_data_o = status_w;
    else if (ptr_i == PTR_SHDN) rd_data_o = shdn_w;
    else                        rd_data_o = '0;
  end

  assign wel_o  = wel_q;
  assign shdn_o = shdn_q;
endmodule

// File: rtl/gatectl_i2c_fsm.sv
module gatectl_i2c_fsm
  import gatectl_i2c_pkg::*;
#(
  parameter int PIN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  addr_pins_i,
  input  logic              wel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic              rnw_q;
  logic [2:0]        tx_idx;

  assign tx_idx = 3'(BYTE_W - 2 - int'(cnt_q));

  logic addr_hit;
  assign addr_hit = (sh_q[BYTE_W-1:BYTE_W-4] == DEV_TYPE) &&
                    (sh_q[PIN_W:1] == addr_pins_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rnw_q     <= 1'b0;
      ptr_o     <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise_i && cnt_q != CNT_W'(BYTE_W)) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe_o <= 1'b1;
                  rnw_q    <= sh_q[0];
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (state_q == ST_PTR) begin
                ptr_o    <= sh_q;
                sda_oe_o <= 1'b1;
                state_q  <= ST_PTR_ACK;
              end else if (ptr_o == PTR_SHDN && !wel_i) begin
                state_q <= ST_WAIT;  // refused: no ack, nothing stored
              end else begin
                sda_oe_o  <= 1'b1;
                wr_en_o   <= 1'b1;
                wr_data_o <= sh_q;
                state_q   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rnw_q) begin
              tx_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[BYTE_W-1];
              state_q  <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_PTR;
            end
          end
          ST_PTR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WAIT;
          end
          ST_RDATA: if (scl_fall_i) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RACK;
            end else begin
              sda_oe_o <= ~tx_q[tx_idx];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_RACK: if (scl_fall_i) state_q <= ST_WAIT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gatectl_i2c_top.sv
module gatectl_i2c_top
  import gatectl_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_W       = 3,
  parameter int GATE_N      = 3,
  parameter int SHDN_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [PIN_W-1:0]  addr_pins_i,
  input  logic [GATE_N-1:0] gate_stat_i,
  output logic [SHDN_W-1:0] shdn_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wel_w, wr_en_w;
  logic [BYTE_W-1:0] ptr_w, wr_data_w, rd_data_w;

  gatectl_i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  gatectl_i2c_fsm #(.PIN_W(PIN_W)) u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_i(sda_s), .addr_pins_i,
    .wel_i(wel_w), .rd_data_i(rd_data_w),
    .sda_oe_o, .ptr_o(ptr_w),
    .wr_en_o(wr_en_w), .wr_data_o(wr_data_w)
  );

  gatectl_i2c_regs #(.GATE_N(GATE_N), .SHDN_W(SHDN_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_w), .ptr_i(ptr_w), .wr_data_i(wr_data_w),
    .gate_stat_i, .rd_data_o(rd_data_w),
    .wel_o(wel_w), .shdn_o
  );
endmodule

// File: rtl/gatectl_i2c_checker.sv
module gatectl_i2c_checker #(
  parameter int SHDN_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe,
  input logic [SHDN_W-1:0] shdn,
  input logic              wel,
  input logic              wr_en,
  input logic              stop_det,
  input logic              scl_s
);
  assert_shdn_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn != $past(shdn)) |-> $past(wel));

  assert_wel_by_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wel != $past(wel)) |-> $past(wr_en));

  assert_stop_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe);

  assert_oe_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_write_acked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> sda_oe);
endmodule

bind gatectl_i2c_top gatectl_i2c_checker #(.SHDN_W(SHDN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe(sda_oe_o), .shdn(shdn_o),
  .wel(wel_w), .wr_en(wr_en_w), .stop_det(stop_det), .scl_s(scl_s)
);

// File: tb/gatectl_i2c_top_test.sv
module gatectl_i2c_top_test;
  localparam int H = 16;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [2:0] pins = 3'b101, gstat = 3'b000;
  logic sda_oe;
  logic [1:0] shdn;
  wire sda_bus = m_sda & ~sda_oe;

  int errs = 0, checks = 0;
  logic exp_wel = 1'b0;
  logic [1:0] exp_shdn = 2'b00;

  always #5 clk = ~clk;

  gatectl_i2c_top uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_pins_i(pins), .gate_stat_i(gstat), .shdn_o(shdn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] p);
    if (p == 8'h00) return {4'b0, gstat, exp_wel};
    if (p == 8'hFF) return {6'b0, exp_shdn};
    return 8'h00;
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; w(H); scl = 1'b1; w(H); m_sda = 1'b0; w(H); scl = 1'b0; w(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(H); scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; w(H); scl = 1'b1; w(H); scl = 1'b0; w(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; w(H); scl = 1'b1; w(H/2);
    ack = ~sda_bus;
    w(H/2); scl = 1'b0; w(4);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl = 1'b1; w(H/2); b[i] = sda_bus; w(H/2); scl = 1'b0; w(4);
    end
    m_sda = 1'b1; w(H); scl = 1'b1; w(H); scl = 1'b0; w(4);  // NACK
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d,
                           output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte({4'b1010, pins, 1'b0}, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d, output logic ak);
    logic a0, a1, a2;
    bus_start();
    send_byte({4'b1010, pins, 1'b0}, a0);
    send_byte(p, a1);
    bus_start();
    send_byte({4'b1010, pins, 1'b1}, a2);
    recv_byte(d);
    bus_stop();
    ak = a0 & a1 & a2;
  endtask

  // model update for a write of d to pointer p; returns the expected data ack
  function automatic logic model_write(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'hFF) begin
      if (!exp_wel) return 1'b0;
      exp_shdn = d[1:0];
    end else if (p == 8'h00) begin
      if (d == 8'h01) exp_wel = 1'b1;
      else if (d == 8'h00) exp_wel = 1'b0;
    end
    return 1'b1;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R7 actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic a0, a1, a2, ak, ea;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    w(5); rst_n = 1'b1; w(5);

    chk("R9 oe after reset", sda_oe, 1'b0);
    chk("R9 shdn after reset", shdn, 2'b00);

    gstat = 3'b101;
    read_reg(8'h00, d, ak);
    chk("R7 read acks", ak, 1'b1);
    chk("R3 status layout, R4 latch reset", d, exp_read(8'h00));

    // wrong device type and wrong pins
    bus_start();
    send_byte({4'b1011, pins, 1'b0}, a0);
    chk("R1 wrong type nack", a0, 1'b0);
    send_byte(8'h00, a1);
    chk("R1 silent after mismatch", a1, 1'b0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, pins ^ 3'b010, 1'b0}, a0);
    chk("R1 wrong pins nack", a0, 1'b0);
    bus_stop();

    // refused shutdown write
    write_reg(8'hFF, 8'h03, a0, a1, a2);
    chk("R2 addr ack", a0, 1'b1);
    chk("R2 ptr ack", a1, 1'b1);
    chk("R5 data nack with latch clear", a2, 1'b0);
    chk("R5 shdn unchanged", shdn, 2'b00);

    write_reg(8'h00, 8'h0E, a0, a1, a2);
    chk("R2 status data ack", a2, 1'b1);
    read_reg(8'h00, d, ak);
    chk("R4 other value keeps latch", d[0], 1'b0);

    write_reg(8'h00, 8'h01, a0, a1, a2); void'(model_write(8'h00, 8'h01));
    read_reg(8'h00, d, ak);
    chk("R4 latch set", d, exp_read(8'h00));

    write_reg(8'hFF, 8'h03, a0, a1, a2); void'(model_write(8'hFF, 8'h03));
    chk("R6 data ack with latch set", a2, 1'b1);
    chk("R6 shdn_o", shdn, 2'b11);
    read_reg(8'hFF, d, ak);
    chk("R6 readback", d, 8'h03);

    write_reg(8'h5A, 8'h01, a0, a1, a2);
    chk("R10 other pointer ack", a2, 1'b1);
    read_reg(8'h5A, d, ak);
    chk("R10 other pointer reads 0", d, 8'h00);

    // abort by stop mid data byte
    bus_start();
    send_byte({4'b1010, pins, 1'b0}, a0);
    send_byte(8'hFF, a1);
    send_bits(8'h00, 4);
    bus_stop();
    chk("R8 stop abort no write", shdn, 2'b11);
    read_reg(8'hFF, d, ak);
    chk("R8 read after stop abort", d, 8'h03);

    // abort by start mid data byte, then a full write
    bus_start();
    send_byte({4'b1010, pins, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_bits(8'h00, 3);
    write_reg(8'hFF, 8'h01, a0, a1, a2); void'(model_write(8'hFF, 8'h01));
    chk("R8 start abort then write ack", a2, 1'b1);
    chk("R8 start abort then write", shdn, 2'b01);
    read_reg(8'h00, d, ak);
    chk("R8 latch kept after abort", d, exp_read(8'h00));

    write_reg(8'h00, 8'h00, a0, a1, a2); void'(model_write(8'h00, 8'h00));
    read_reg(8'h00, d, ak);
    chk("R4 latch cleared", d, exp_read(8'h00));

    for (int it = 0; it < 24; it++) begin
      int op;
      logic [7:0] v;
      op = int'($urandom % 6);
      v = 8'($urandom);
      pins = 3'($urandom);
      gstat = 3'($urandom);
      case (op)
        0: v = 8'h01;
        1: v = 8'h00;
        default: ;
      endcase
      if (op <= 2) begin
        write_reg(8'h00, v, a0, a1, a2); ea = model_write(8'h00, v);
        chk("R2 random status write ack", {a0, a1, a2}, {2'b11, ea});
      end else if (op == 3) begin
        write_reg(8'hFF, v, a0, a1, a2); ea = model_write(8'hFF, v);
        chk("R5 R6 random shutdown write ack", {a0, a1, a2}, {2'b11, ea});
        chk("R6 random shdn_o", shdn, exp_shdn);
      end else begin
        read_reg(op == 4 ? 8'h00 : 8'hFF, d, ak);
        chk("R7 random read ack", ak, 1'b1);
        chk("R3 random read data", d, exp_read(op == 4 ? 8'h00 : 8'hFF));
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule